// File: doc/BRIEF.md
# UART Serial Transceiver

A full-duplex asynchronous serial port that runs from one system clock. The transmit side takes a byte on a valid/ready handshake and shifts it out on `txd`. The receive side watches `rxd`, rebuilds each byte and hands it over with a one-cycle valid strobe, along with a parity error flag and a framing error flag. The bit period is `CLK_HZ / BAUD` clock cycles. Any rate is allowed provided that ratio stays below 65536; typical rates run from 9600 to 921600 baud. Every frame carries eight data bits, least significant bit first. A parity bit, when enabled, follows the data and comes before one or two stop bits.

Both directions use the same state set, `uart_xcvr_pkg::frame_st_e`:

- **FR_IDLE**
  - The transmitter moves to FR_START when `tx_valid` is high.
  - The receiver moves to FR_START when the synchronised line reads low.
- **FR_START**
  - The transmitter moves to FR_DATA after one bit period.
  - The receiver checks the line after half a bit period. It moves to FR_DATA if the line is still low, and otherwise returns to FR_IDLE because the low pulse was a glitch.
- **FR_DATA** moves to FR_PARITY after the eighth bit. When parity is off it moves to FR_STOP instead.
- **FR_PARITY** moves to FR_STOP after one bit period.
- **FR_STOP** returns to FR_IDLE after the last stop bit. At that point the receiver raises `rx_valid`.

The receiver takes each sample at mid-bit. All sample times are counted from the falling edge of the start bit, after a two-flop synchroniser.

Top module: `uart_xcvr`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), and directly after reset, `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: The transmitter sends a start bit of 0, then data bits 0 to 7 in that order. Each bit lasts `CLK_HZ/BAUD` cycles, and that count is held in a 16-bit counter. The start bit appears on `txd` in the cycle after the handshake.
- R3: The `PARITY` parameter selects the parity mode: 0 none, 1 even (the XOR of the data), 2 odd (the inverted XOR), 3 mark (constant 1), 4 space (constant 0). The parity bit follows bit 7 on both the transmit and receive sides.
- R4: The transmitter ends each frame with `STOP_BITS` (1 or 2) high bits and then returns to idle.
- R5: A byte is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low until the frame ends, and `txd` is high whenever `tx_ready` is high.
- R6: The receiver delivers each byte with `rx_valid` high for exactly one cycle. `rx_data`, `rx_parity_err` and `rx_frame_err` hold their values between strobes.
- R7: `rx_parity_err` is 1 when the received parity bit differs from the value the mode calls for.
- R8: `rx_frame_err` is 1 when any of the stop bits samples low, including only the second of two stop bits.
- R9: A low pulse on `rxd` that has ended by the middle of the start bit produces no byte, and the receiver then accepts the next frame normally.
- R10: Reception and transmission run independently and at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line, high when idle |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmitter idle, can accept a byte |
| rx_valid | output | 1 | One-cycle strobe, received byte available |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity mismatch on the byte just delivered |
| rx_frame_err | output | 1 | Low stop bit on the byte just delivered |

## Verification
Delivering a received byte and accepting a new byte for transmission can happen in the same cycle, because the two state machines share nothing but the clock. The bench provokes this by running a back-to-back transmit burst in parallel with two incoming frames, so that handshakes and receive strobes overlap in time. A scoreboard queue for each direction judges the outcome: every transmitted frame must decode bit for bit at mid-bit, and every strobe must match the frame that was driven, with the right error flags.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_EVEN  = 3'd1,
        PAR_ODD   = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PARITY,
        FR_STOP
    } frame_st_e;

    // Parity bit that the given mode attaches to a byte
    function automatic logic par_bit(input par_mode_e mode, input logic [7:0] d);
        logic r;
        unique case (mode)
            PAR_EVEN:  r = ^d;
            PAR_ODD:   r = ~^d;
            PAR_MARK:  r = 1'b1;
            PAR_SPACE: r = 1'b0;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_xcvr_pkg::*;
#(
    parameter int unsigned DIV   = 434,
    parameter par_mode_e   PMODE = PAR_NONE,
    parameter int unsigned NSTOP = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid,
    input  logic [7:0] data,
    output logic       ready,
    output logic       txd
);
    localparam logic [15:0] FULL_M1 = 16'(DIV - 1);

    frame_st_e   st_q, st_d;
    logic [15:0] cnt_q;
    logic [2:0]  bit_q;
    logic        stop_q;
    logic [7:0]  sh_q;
    logic        pb_q;
    logic        tick;
    logic        last_stop;

    assign tick      = (cnt_q == 16'd0);
    assign last_stop = (stop_q == 1'(NSTOP - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE:   if (valid) st_d = FR_START;
            FR_START:  if (tick) st_d = FR_DATA;
            FR_DATA:   if (tick && bit_q == 3'd7)
                           st_d = (PMODE == PAR_NONE) ? FR_STOP : FR_PARITY;
            FR_PARITY: if (tick) st_d = FR_STOP;
            FR_STOP:   if (tick && last_stop) st_d = FR_IDLE;
            default:   st_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= FULL_M1;
            bit_q  <= 3'd0;
            stop_q <= 1'b0;
            sh_q   <= 8'd0;
            pb_q   <= 1'b0;
        end else if (st_q == FR_IDLE) begin
            cnt_q  <= FULL_M1;
            bit_q  <= 3'd0;
            stop_q <= 1'b0;
            if (valid) begin
                sh_q <= data;
                pb_q <= par_bit(PMODE, data);
            end
        end else begin
            cnt_q <= tick ? FULL_M1 : cnt_q - 16'd1;
            if (tick && st_q == FR_DATA) begin
                sh_q  <= {1'b0, sh_q[7:1]};
                bit_q <= bit_q + 3'd1;
            end
            if (tick && st_q == FR_STOP) stop_q <= stop_q + 1'b1;
        end
    end

    // Output decode
    always_comb begin
        ready = (st_q == FR_IDLE);
        unique case (st_q)
            FR_START:  txd = 1'b0;
            FR_DATA:   txd = sh_q[0];
            FR_PARITY: txd = pb_q;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_xcvr_pkg::*;
#(
    parameter int unsigned DIV   = 434,
    parameter par_mode_e   PMODE = PAR_NONE,
    parameter int unsigned NSTOP = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    localparam logic [15:0] FULL_M1 = 16'(DIV - 1);
    localparam logic [15:0] HALF_M1 = 16'(DIV / 2 - 1);

    frame_st_e   st_q, st_d;
    logic        rx_m, rx_s;
    logic [15:0] cnt_q;
    logic [2:0]  bit_q;
    logic        stop_q;
    logic [7:0]  sh_q;
    logic        pok_q;
    logic        fe_q;
    logic        tick;
    logic        last_stop;
    logic        done;

    assign tick      = (cnt_q == 16'd0);
    assign last_stop = (stop_q == 1'(NSTOP - 1));
    assign done      = (st_q == FR_STOP) && tick && last_stop;

    // Two-flop synchroniser
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE:   if (!rx_s) st_d = FR_START;
            FR_START:  if (tick) st_d = rx_s ? FR_IDLE : FR_DATA;
            FR_DATA:   if (tick && bit_q == 3'd7)
                           st_d = (PMODE == PAR_NONE) ? FR_STOP : FR_PARITY;
            FR_PARITY: if (tick) st_d = FR_STOP;
            FR_STOP:   if (tick && last_stop) st_d = FR_IDLE;
            default:   st_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= HALF_M1;
            bit_q  <= 3'd0;
            stop_q <= 1'b0;
            sh_q   <= 8'd0;
            pok_q  <= 1'b1;
            fe_q   <= 1'b0;
        end else if (st_q == FR_IDLE) begin
            cnt_q  <= HALF_M1;
            bit_q  <= 3'd0;
            stop_q <= 1'b0;
            pok_q  <= 1'b1;
            fe_q   <= 1'b0;
        end else begin
            cnt_q <= tick ? FULL_M1 : cnt_q - 16'd1;
            if (tick && st_q == FR_DATA) begin
                sh_q  <= {rx_s, sh_q[7:1]};
                bit_q <= bit_q + 3'd1;
            end
            if (tick && st_q == FR_PARITY) pok_q <= (rx_s == par_bit(PMODE, sh_q));
            if (tick && st_q == FR_STOP) begin
                stop_q <= stop_q + 1'b1;
                if (!rx_s) fe_q <= 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= 8'd0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            valid <= done;
            if (done) begin
                data <= sh_q;
                perr <= !pok_q;
                ferr <= fe_q | !rx_s;
            end
        end
    end

endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
    import uart_xcvr_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned BAUD      = 115_200,
    parameter int          PARITY    = 0,
    parameter int unsigned STOP_BITS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       txd,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_parity_err,
    output logic       rx_frame_err
);
    localparam int unsigned DIV   = CLK_HZ / BAUD;
    localparam par_mode_e   PMODE = par_mode_e'(PARITY[2:0]);

    uart_tx_core #(.DIV(DIV), .PMODE(PMODE), .NSTOP(STOP_BITS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (tx_valid),
        .data  (tx_data),
        .ready (tx_ready),
        .txd   (txd)
    );

    uart_rx_core #(.DIV(DIV), .PMODE(PMODE), .NSTOP(STOP_BITS)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd   (rxd),
        .valid (rx_valid),
        .data  (rx_data),
        .perr  (rx_parity_err),
        .ferr  (rx_frame_err)
    );

endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_parity_err,
    input logic       rx_frame_err
);
    // R5
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    // R5
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !txd);

    // R6
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_parity_err) && $stable(rx_frame_err)));
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .txd           (txd),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_parity_err (rx_parity_err),
    .rx_frame_err  (rx_frame_err)
);

// File: tb/tb_uart_xcvr.sv
`timescale 1ns/1ps
module tb_uart_xcvr;
    localparam int BIT  = 16;
    localparam int HALF = BIT / 2;
    localparam int MODE_A = 2;   // odd parity, two stop bits
    localparam int STOP_A = 2;
    localparam int MODE_M = 3;   // mark parity, one stop bit
    localparam int STOP_M = 1;

    logic clk = 1'b0;
    logic rst_n;
    always #2.5 clk = ~clk;

    logic       rxd_a, txd_a, txv_a, txr_a, rxv_a, rpe_a, rfe_a;
    logic [7:0] txd8_a, rxd8_a;
    logic       rxd_m, txd_m, txv_m, txr_m, rxv_m, rpe_m, rfe_m;
    logic [7:0] txd8_m, rxd8_m;

    uart_xcvr #(.CLK_HZ(200_000_000), .BAUD(12_500_000), .PARITY(MODE_A), .STOP_BITS(STOP_A)) dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd_a), .txd(txd_a), .tx_valid(txv_a), .tx_data(txd8_a),
        .tx_ready(txr_a), .rx_valid(rxv_a), .rx_data(rxd8_a), .rx_parity_err(rpe_a), .rx_frame_err(rfe_a));

    uart_xcvr #(.CLK_HZ(200_000_000), .BAUD(12_500_000), .PARITY(MODE_M), .STOP_BITS(STOP_M)) dut_m (
        .clk(clk), .rst_n(rst_n), .rxd(rxd_m), .txd(txd_m), .tx_valid(txv_m), .tx_data(txd8_m),
        .tx_ready(txr_m), .rx_valid(rxv_m), .rx_data(rxd8_m), .rx_parity_err(rpe_m), .rx_frame_err(rfe_m));

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] txq[$];
    logic [9:0] rxq[$];   // {perr, ferr, data}
    int rx_seen = 0;
    int m_cnt = 0;
    logic [9:0] m_last = '0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic pbit(input int mode, input logic [7:0] d);
        case (mode)
            1: return ^d;
            2: return ~^d;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic line_of(input bit w);
        return w ? txd_m : txd_a;
    endfunction

    task automatic set_rx(input bit w, input logic v);
        if (w) rxd_m = v; else rxd_a = v;
    endtask

    // Driver: offer a byte on the transmit handshake
    task automatic send_tx(input bit w, input logic [7:0] d);
        @(negedge clk);
        while (!(w ? txr_m : txr_a)) @(negedge clk);
        if (w) begin txv_m = 1'b1; txd8_m = d; end
        else begin txv_a = 1'b1; txd8_a = d; txq.push_back(d); end
        @(negedge clk);
        if (w) txv_m = 1'b0; else txv_a = 1'b0;
        chk((w ? txr_m : txr_a) == 1'b0, "R5", "ready low after accept", int'(w ? txr_m : txr_a), 0);
    endtask

    // Decode one transmitted frame; called at the first negedge showing the start bit
    task automatic check_tx_frame(input bit w, input logic [7:0] exp, input int mode, input int nstop);
        logic [7:0] got;
        logic b;
        repeat (HALF) @(negedge clk);
        b = line_of(w);
        chk(b == 1'b0, "R2", "start bit", int'(b), 0);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            got[i] = line_of(w);
        end
        chk(got == exp, "R2", "tx data", int'(got), int'(exp));
        if (mode != 0) begin
            repeat (BIT) @(negedge clk);
            b = line_of(w);
            chk(b == pbit(mode, exp), "R3", "tx parity bit", int'(b), int'(pbit(mode, exp)));
        end
        for (int s = 0; s < nstop; s++) begin
            repeat (BIT) @(negedge clk);
            b = line_of(w);
            chk(b == 1'b1, "R4", "tx stop bit", int'(b), 1);
        end
    endtask

    // Drive one frame into a receiver
    task automatic drive_rx(input bit w, input logic [7:0] d, input bit flip_par, input bit bad_stop);
        int mode  = w ? MODE_M : MODE_A;
        int nstop = w ? STOP_M : STOP_A;
        if (!w) rxq.push_back({flip_par, bad_stop, d});
        @(negedge clk);
        set_rx(w, 1'b0);
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            set_rx(w, d[i]);
            repeat (BIT) @(negedge clk);
        end
        if (mode != 0) begin
            set_rx(w, pbit(mode, d) ^ flip_par);
            repeat (BIT) @(negedge clk);
        end
        for (int s = 0; s < nstop; s++) begin
            if (bad_stop && s == nstop - 1) begin
                set_rx(w, 1'b0);
                repeat (BIT * 3 / 4) @(negedge clk);
                set_rx(w, 1'b1);
                repeat (BIT - BIT * 3 / 4) @(negedge clk);
            end else begin
                set_rx(w, 1'b1);
                repeat (BIT) @(negedge clk);
            end
        end
        set_rx(w, 1'b1);
        repeat (BIT) @(negedge clk);
    endtask

    // Monitor: transmit scoreboard for dut
    initial begin
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            if (txd_a === 1'b0) begin
                if (txq.size() == 0) begin
                    chk(1'b0, "R5", "unexpected tx frame", 0, 1);
                    repeat (BIT * 12) @(negedge clk);
                end else begin
                    logic [7:0] e;
                    e = txq.pop_front();
                    check_tx_frame(1'b0, e, MODE_A, STOP_A);
                end
            end
        end
    end

    // Monitor: receive scoreboard for dut
    initial begin
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            if (rxv_a === 1'b1) begin
                rx_seen++;
                if (rxq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected rx byte", int'(rxd8_a), 0);
                end else begin
                    logic [9:0] e;
                    e = rxq.pop_front();
                    chk(rxd8_a == e[7:0], "R6", "rx data", int'(rxd8_a), int'(e[7:0]));
                    chk(rpe_a == e[9], "R7", "rx parity error flag", int'(rpe_a), int'(e[9]));
                    chk(rfe_a == e[8], "R8", "rx framing error flag", int'(rfe_a), int'(e[8]));
                end
            end
        end
    end

    // Monitor: receive results of dut_m
    initial begin
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            if (rxv_m === 1'b1) begin
                m_cnt++;
                m_last = {rpe_m, rfe_m, rxd8_m};
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        rst_n = 1'b0;
        rxd_a = 1'b1; rxd_m = 1'b1;
        txv_a = 1'b0; txv_m = 1'b0;
        txd8_a = 8'd0; txd8_m = 8'd0;
        repeat (5) @(negedge clk);
        // R1: reset state of both instances
        chk(txd_a == 1'b1 && txd_m == 1'b1, "R1", "txd in reset", int'({txd_a, txd_m}), 3);
        chk(txr_a == 1'b1 && txr_m == 1'b1, "R1", "tx_ready in reset", int'({txr_a, txr_m}), 3);
        chk(rxv_a == 1'b0 && rxv_m == 1'b0, "R1", "rx_valid in reset", int'({rxv_a, rxv_m}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(txd_a == 1'b1 && txr_a == 1'b1, "R1", "idle after reset", int'({txd_a, txr_a}), 3);

        // R10: transmit burst overlapping two incoming frames
        fork
            begin
                send_tx(1'b0, 8'h55);
                send_tx(1'b0, 8'hA3);
                send_tx(1'b0, 8'h00);
                send_tx(1'b0, 8'hFF);
            end
            begin
                drive_rx(1'b0, 8'h3C, 1'b0, 1'b0);
                drive_rx(1'b0, 8'h81, 1'b0, 1'b0);
            end
        join

        // R7: wrong parity; R8: second stop bit low; then a clean frame
        drive_rx(1'b0, 8'h5A, 1'b1, 1'b0);
        drive_rx(1'b0, 8'hC3, 1'b0, 1'b1);
        drive_rx(1'b0, 8'h7E, 1'b0, 1'b0);

        // R9: short low pulse is rejected, next frame still received
        c0 = rx_seen;
        @(negedge clk);
        rxd_a = 1'b0;
        repeat (HALF / 2) @(negedge clk);
        rxd_a = 1'b1;
        repeat (BIT * 3) @(negedge clk);
        chk(rx_seen == c0, "R9", "byte count after glitch", rx_seen, c0);
        drive_rx(1'b0, 8'h96, 1'b0, 1'b0);
        chk(rx_seen == c0 + 1, "R9", "byte count after recovery", rx_seen, c0 + 1);

        // R3 mark parity and R4 single stop on dut_m
        fork
            send_tx(1'b1, 8'h6E);
            begin
                @(negedge clk);
                while (txd_m !== 1'b0) @(negedge clk);
                check_tx_frame(1'b1, 8'h6E, MODE_M, STOP_M);
            end
        join
        repeat (HALF + 2) @(negedge clk);
        chk(txr_m == 1'b1 && txd_m == 1'b1, "R4", "idle after single stop", int'({txr_m, txd_m}), 3);

        c0 = m_cnt;
        drive_rx(1'b1, 8'h2D, 1'b0, 1'b0);
        chk(m_cnt == c0 + 1, "R6", "dut_m byte count", m_cnt, c0 + 1);
        chk(m_last == {2'b00, 8'h2D}, "R3", "mark parity accepted", int'(m_last), int'({2'b00, 8'h2D}));
        drive_rx(1'b1, 8'h2D, 1'b1, 1'b0);
        chk(m_last == {2'b10, 8'h2D}, "R7", "mark parity mismatch", int'(m_last), int'({2'b10, 8'h2D}));

        for (int k = 0; k < 2000 && (txq.size() != 0 || rxq.size() != 0); k++) @(negedge clk);
        repeat (BIT * 4) @(negedge clk);
        chk(txq.size() == 0 && rxq.size() == 0, "R10", "scoreboards drained",
            txq.size() + rxq.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule